// File: doc/BRIEF.md
# Halfword Storage Address Decoder

This block turns a 16-bit halfword storage address into the chip-level select lines of a banked, byte-wide read/write memory. Address bits are numbered 0 (most significant, port bit 15) through F (least significant, port bit 0). An address whose nine upper bits (0 to 8) are all zero goes to a small internal register file. Any other address goes to one of four external storage cards. On a card access the address is split into a card number, an X/Y group choice inside the card and a 10-bit byte address whose bits are taken from the halfword address in a permuted order.

Write strobes go to two banks. The even bank holds one card of each pair and the odd bank holds the other. A byte write drives one strobe, picked by bit F. A halfword write drives both. During instruction-fetch cycles a ROM-select input acts as one more address bit and sends the access to executable control ROM instead.

All outputs are registered. An access presented with `accValid` high at a rising edge appears on the outputs after that edge. A cycle without `accValid` clears every select and strobe at the next edge.

Top module: `hsd_top`

## Requirements
- R1: While `rstN` is low, every output is zero.
- R2: When `accAddr[15:7]` is all zero and the access is not redirected to ROM, `regFileSel` is 1 and `regFileAddr` equals `accAddr[6:1]`. `cardSel`, `csx`, `csy`, `wrEven` and `wrOdd` are all zero. The boundary address 0x0080 is a card access.
- R3: When any bit of `accAddr[15:7]` is 1 and the access is not redirected, `cardSel` is one-hot with bit index `accAddr[15:14]` (00 gives bit 0, 11 gives bit 3), and `regFileSel` is 0.
- R4: On a card access, `csx` is one-hot with bit index `accAddr[12:11]`. `csy[0]` is 1 when `accAddr[10]` is 0, and `csy[1]` is 1 when it is 1. On any other access both are zero.
- R5: On every accepted access, `sarAddr[0]` through `sarAddr[9]` take `accAddr` bits 1, 2, 3, 4, 5, 6, 7, 8, 9 and 13 in that order. These are address bits E, D, C, B, A, 9, 8, 7, 6 and 2 in the MSB-first numbering.
- R6: On a card byte write (`accWrite`=1, `accHalf`=0), `wrEven` is 1 and `wrOdd` is 0 when `accAddr[0]` is 0. The opposite holds when `accAddr[0]` is 1.
- R7: On a card halfword write (`accWrite`=1, `accHalf`=1), both `wrEven` and `wrOdd` are 1, whatever the value of `accAddr[0]`.
- R8: With `accWrite`=0, and on any register-file or ROM access, `wrEven` and `wrOdd` are 0.
- R9: When `fetchCycle` and `romSelIn` are both 1, `romHit` is 1. `regFileSel`, `regFileAddr`, `cardSel`, `csx`, `csy`, `wrEven` and `wrOdd` are all zero, and `sarAddr` still follows R5.
- R10: When `fetchCycle` is 0, `romSelIn` has no effect, and `romHit` stays 0.
- R11: Outputs reflect the access sampled at the rising edge where `accValid` is 1, and `outValid` is 1 for that cycle. After an edge where `accValid` is 0, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | Access strobe; loads the output stage |
| accAddr | input | 16 | Halfword storage address, bit 15 is address bit 0 |
| accWrite | input | 1 | Access is a write |
| accHalf | input | 1 | Write covers a full halfword |
| fetchCycle | input | 1 | Current access is an instruction fetch |
| romSelIn | input | 1 | Extra address bit during fetch, selects control ROM |
| outValid | output | 1 | Registered outputs carry an access |
| regFileSel | output | 1 | Internal register file selected |
| regFileAddr | output | 6 | Register file address |
| romHit | output | 1 | Control ROM selected |
| cardSel | output | 4 | One-hot storage card select |
| csx | output | 4 | One-hot X group select |
| csy | output | 2 | One-hot Y group select |
| sarAddr | output | 10 | Byte address within the selected group |
| wrEven | output | 1 | Write strobe to the even card bank |
| wrOdd | output | 1 | Write strobe to the odd card bank |

## Verification
The bench builds the block with the package defaults: a 16-bit address, four cards, a 4-by-2 group grid and a 10-bit byte address. Under these values every card line and all eight X/Y combinations can be reached by stepping the card and group fields. Walking a single 1 across each byte-address source bit shows the permutation one line at a time. The window edge at 0x007E/0x0080 and the fetch-redirect cases, with and without the fetch qualifier, are reachable directly.

// File: rtl/hsd_pkg.sv
package hsd_pkg;
  localparam int ADDR_W  = 16;
  localparam int UPPER_N = 9;
  localparam int CARD_N  = 4;
  localparam int CSX_N   = 4;
  localparam int CSY_N   = 2;
  localparam int SAR_W   = 10;
  localparam int RF_W    = 6;

  localparam int CARD_SW = $clog2(CARD_N);
  localparam int CSX_SW  = $clog2(CSX_N);
  localparam int CSY_SW  = $clog2(CSY_N);

  // port bit positions (address bit n in MSB-first numbering is port bit ADDR_W-1-n)
  localparam int CARD_MSB = ADDR_W - 1;
  localparam int CSX_MSB  = CARD_MSB - CARD_SW - 1;
  localparam int CSY_MSB  = CSX_MSB - CSX_SW;
  localparam int RF_MSB   = RF_W;

  typedef struct packed {
    logic load;
    logic regWin;
    logic romWin;
    logic cardWin;
    logic wrEven;
    logic wrOdd;
  } ctrlStrobes_t;
endpackage

// File: rtl/hsd_ctrl.sv
module hsd_ctrl
  import hsd_pkg::*;
(
  input  logic               accValid,
  input  logic [UPPER_N-1:0] upperField,
  input  logic               lowBit,
  input  logic               accWrite,
  input  logic               accHalf,
  input  logic               fetchCycle,
  input  logic               romSelIn,
  output ctrlStrobes_t       strobes
);
  logic upperAny;
  logic writeOk;

  always_comb begin
    upperAny = |upperField;
    strobes.load    = accValid;
    strobes.romWin  = fetchCycle & romSelIn;
    strobes.regWin  = !strobes.romWin & !upperAny;
    strobes.cardWin = !strobes.romWin & upperAny;
    writeOk         = accValid & accWrite & strobes.cardWin;
    strobes.wrEven  = writeOk & (accHalf | !lowBit);
    strobes.wrOdd   = writeOk & (accHalf | lowBit);
  end
endmodule

// File: rtl/hsd_datapath.sv
module hsd_datapath
  import hsd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:1] addrHi,
  output logic              outValid,
  output logic              regFileSel,
  output logic [RF_W-1:0]   regFileAddr,
  output logic              romHit,
  output logic [CARD_N-1:0] cardSel,
  output logic [CSX_N-1:0]  csx,
  output logic [CSY_N-1:0]  csy,
  output logic [SAR_W-1:0]  sarAddr,
  output logic              wrEven,
  output logic              wrOdd
);
  // byte-address sources in MSB-first address numbering, line 1 first
  localparam int SAR_SRC [SAR_W] = '{14, 13, 12, 11, 10, 9, 8, 7, 6, 2};

  logic [CARD_SW-1:0] cardField;
  logic [CSX_SW-1:0]  csxField;
  logic [CSY_SW-1:0]  csyField;
  logic [CARD_N-1:0]  cardDec;
  logic [CSX_N-1:0]   csxDec;
  logic [CSY_N-1:0]   csyDec;
  logic [SAR_W-1:0]   sarNext;

  assign cardField = addrHi[CARD_MSB -: CARD_SW];
  assign csxField  = addrHi[CSX_MSB -: CSX_SW];
  assign csyField  = addrHi[CSY_MSB -: CSY_SW];

  for (genvar i = 0; i < CARD_N; i++) begin : g_card
    assign cardDec[i] = (cardField == CARD_SW'(i));
  end
  for (genvar i = 0; i < CSX_N; i++) begin : g_csx
    assign csxDec[i] = (csxField == CSX_SW'(i));
  end
  for (genvar i = 0; i < CSY_N; i++) begin : g_csy
    assign csyDec[i] = (csyField == CSY_SW'(i));
  end
  for (genvar i = 0; i < SAR_W; i++) begin : g_sar
    assign sarNext[i] = addrHi[ADDR_W - 1 - SAR_SRC[i]];
  end

  always_ff @(posedge clk) begin
    if (!rstN || !strobes.load) begin
      outValid    <= 1'b0;
      regFileSel  <= 1'b0;
      regFileAddr <= '0;
      romHit      <= 1'b0;
      cardSel     <= '0;
      csx         <= '0;
      csy         <= '0;
      sarAddr     <= '0;
      wrEven      <= 1'b0;
      wrOdd       <= 1'b0;
    end else begin
      outValid    <= 1'b1;
      regFileSel  <= strobes.regWin;
      regFileAddr <= strobes.regWin ? addrHi[RF_MSB -: RF_W] : '0;
      romHit      <= strobes.romWin;
      cardSel     <= strobes.cardWin ? cardDec : '0;
      csx         <= strobes.cardWin ? csxDec : '0;
      csy         <= strobes.cardWin ? csyDec : '0;
      sarAddr     <= sarNext;
      wrEven      <= strobes.wrEven;
      wrOdd       <= strobes.wrOdd;
    end
  end

  // R3
  card_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cardSel));

  // R9
  target_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({regFileSel, romHit, |cardSel}));

  // R4
  group_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|cardSel) |-> ($countones(csx) == 1 && $countones(csy) == 1));

  // R4
  group_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(|cardSel) |-> (csx == '0 && csy == '0));

  // R8
  strobe_needs_card_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEven || wrOdd) |-> (|cardSel));

  // R11
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> (!outValid && cardSel == '0 && !wrEven && !wrOdd && !regFileSel));

  // R5
  sar_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (sarAddr[SAR_W-1] == $past(addrHi[ADDR_W-1-SAR_SRC[SAR_W-1]])));

  // R9
  rom_redirect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && strobes.romWin) |=> (romHit && !regFileSel && !wrEven && !wrOdd));
endmodule

// File: rtl/hsd_top.sv
module hsd_top
  import hsd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accWrite,
  input  logic              accHalf,
  input  logic              fetchCycle,
  input  logic              romSelIn,
  output logic              outValid,
  output logic              regFileSel,
  output logic [RF_W-1:0]   regFileAddr,
  output logic              romHit,
  output logic [CARD_N-1:0] cardSel,
  output logic [CSX_N-1:0]  csx,
  output logic [CSY_N-1:0]  csy,
  output logic [SAR_W-1:0]  sarAddr,
  output logic              wrEven,
  output logic              wrOdd
);
  ctrlStrobes_t strobes;

  hsd_ctrl ctrl_i (
    .accValid   (accValid),
    .upperField (accAddr[ADDR_W-1 -: UPPER_N]),
    .lowBit     (accAddr[0]),
    .accWrite   (accWrite),
    .accHalf    (accHalf),
    .fetchCycle (fetchCycle),
    .romSelIn   (romSelIn),
    .strobes    (strobes)
  );

  hsd_datapath dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .addrHi      (accAddr[ADDR_W-1:1]),
    .outValid    (outValid),
    .regFileSel  (regFileSel),
    .regFileAddr (regFileAddr),
    .romHit      (romHit),
    .cardSel     (cardSel),
    .csx         (csx),
    .csy         (csy),
    .sarAddr     (sarAddr),
    .wrEven      (wrEven),
    .wrOdd       (wrOdd)
  );
endmodule

// File: tb/hsd_top_tb_top.sv
module hsd_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accValid = 1'b0;
  logic [15:0] accAddr = '0;
  logic        accWrite = 1'b0;
  logic        accHalf = 1'b0;
  logic        fetchCycle = 1'b0;
  logic        romSelIn = 1'b0;
  logic        outValid, regFileSel, romHit, wrEven, wrOdd;
  logic [5:0]  regFileAddr;
  logic [3:0]  cardSel, csx;
  logic [1:0]  csy;
  logic [9:0]  sarAddr;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hsd_top dut_i (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accAddr(accAddr),
    .accWrite(accWrite), .accHalf(accHalf), .fetchCycle(fetchCycle),
    .romSelIn(romSelIn), .outValid(outValid), .regFileSel(regFileSel),
    .regFileAddr(regFileAddr), .romHit(romHit), .cardSel(cardSel),
    .csx(csx), .csy(csy), .sarAddr(sarAddr), .wrEven(wrEven), .wrOdd(wrOdd)
  );

  // expected outputs from the requirements:
  // {outValid, regFileSel, romHit, regFileAddr, cardSel, csx, csy, sarAddr, wrEven, wrOdd}
  function automatic logic [30:0] model(input logic v, input logic [15:0] a,
                                        input logic wr, input logic half,
                                        input logic fetch, input logic rom);
    int src [10] = '{1, 2, 3, 4, 5, 6, 7, 8, 9, 13};
    logic romW, regW, cardW, we, wo;
    logic [5:0] rfa;
    logic [3:0] card, x;
    logic [1:0] y;
    logic [9:0] sar;
    if (!v) return '0;
    romW  = fetch & rom;
    regW  = !romW && (a[15:7] == 9'd0);
    cardW = !romW && (a[15:7] != 9'd0);
    rfa   = regW ? a[6:1] : 6'd0;
    card  = cardW ? (4'b0001 << a[15:14]) : 4'd0;
    x     = cardW ? (4'b0001 << a[12:11]) : 4'd0;
    y     = cardW ? (a[10] ? 2'b10 : 2'b01) : 2'd0;
    for (int i = 0; i < 10; i++) sar[i] = a[src[i]];
    we = cardW && wr && (half || !a[0]);
    wo = cardW && wr && (half || a[0]);
    return {1'b1, regW, romW, rfa, card, x, y, sar, we, wo};
  endfunction

  task automatic compare(input string tag, input logic [30:0] exp);
    logic [30:0] got;
    got = {outValid, regFileSel, romHit, regFileAddr, cardSel, csx, csy, sarAddr, wrEven, wrOdd};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  // present one access for one edge, then check the registered result
  task automatic access(input string tag, input logic [15:0] a, input logic wr,
                        input logic half, input logic fetch, input logic rom);
    @(negedge clk);
    accValid = 1'b1; accAddr = a; accWrite = wr; accHalf = half;
    fetchCycle = fetch; romSelIn = rom;
    @(negedge clk);
    accValid = 1'b0;
    compare(tag, model(1'b1, a, wr, half, fetch, rom));
  endtask

  task automatic testReset();
    compare("R1 reset", '0);
    @(negedge clk);
    compare("R1 reset held", '0);
  endtask

  task automatic testRegWindow();
    access("R2 reg zero", 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0);
    access("R2 reg top", 16'h007E, 1'b1, 1'b1, 1'b0, 1'b0);
    access("R2 reg write", 16'h0042, 1'b1, 1'b0, 1'b0, 1'b0);
    access("R2 edge to card", 16'h0080, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic testCards();
    for (int c = 0; c < 4; c++)
      access("R3 card", 16'h0080 | 16'(c << 14), 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic testGroups();
    for (int g = 0; g < 8; g++)
      access("R4 group", 16'h4000 | 16'(g << 10), 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic testSar();
    int bits [10] = '{1, 2, 3, 4, 5, 6, 7, 8, 9, 13};
    for (int i = 0; i < 10; i++)
      access("R5 sar walk", 16'hC000 | 16'(1 << bits[i]), 1'b0, 1'b0, 1'b0, 1'b0);
    access("R5 sar all", 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic testByteWrite();
    access("R6 even", 16'h4000, 1'b1, 1'b0, 1'b0, 1'b0);
    access("R6 odd", 16'h4001, 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic testHalfWrite();
    access("R7 half even addr", 16'h8000, 1'b1, 1'b1, 1'b0, 1'b0);
    access("R7 half odd addr", 16'h8001, 1'b1, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic testRead();
    access("R8 read", 16'h4001, 1'b0, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic testRom();
    access("R9 rom card addr", 16'h4001, 1'b1, 1'b1, 1'b1, 1'b1);
    access("R9 rom low addr", 16'h0010, 1'b0, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic testRomIgnored();
    access("R10 no fetch", 16'h8000, 1'b1, 1'b0, 1'b0, 1'b1);
    access("R10 fetch no rom", 16'h0004, 1'b0, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic testIdle();
    access("R11 load", 16'hC3FF, 1'b1, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    compare("R11 idle clear", '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testRegWindow();
    testCards();
    testGroups();
    testSar();
    testByteWrite();
    testHalfWrite();
    testRead();
    testRom();
    testRomIgnored();
    testIdle();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule